// File: doc/BRIEF.md
# Serial Converter Power-Mode Controller

This block tracks the power state of a serial-interface converter purely from the host's chip-select and serial-clock activity, so no register write is needed. While chip-select is low it counts falling serial-clock edges. The count reached at the moment chip-select is released picks the outcome. A frame released early, but not too early, sends a running device into a shallow sleep. The same kind of release while already in the shallow sleep sends it into a deep sleep. A release with very few edges is treated as a glitch and changes nothing.

Waking is done with a dummy frame. Chip-select falling starts power-up from either sleep depth. The wake is only committed once chip-select has stayed low past the 10th falling clock edge, and the device then waits out a power-up time that depends on the sleep depth it left. Both power-up times are counted in cycles of a free-running system clock. The dummy frame's data is flagged invalid, and the next frame after power-up is flagged valid. Both inputs pass through two-flop synchronizers before any edge is detected.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After reset, pstate is 00, ready is 1 and data_valid is 0.
- R2: In normal state (pstate 00), chip-select rising after 2 to 9 falling clock edges of the frame moves pstate to 01 (partial power-down).
- R3: In normal state, a frame released after fewer than 2 falling edges, or after 10 or more, leaves pstate at 00.
- R4: In partial power-down, a frame released after fewer than 2 falling edges returns pstate to 01.
- R5: In partial power-down, a frame released after 2 to 9 falling edges moves pstate to 10 (full power-down).
- R6: In full power-down, a frame released after fewer than 10 falling edges returns pstate to 10.
- R7: Chip-select falling in either power-down state moves pstate to 11 (powering up). If chip-select then stays low through the 10th falling edge, pstate becomes 00 once PU_PART_CYC system cycles (from partial) or PU_FULL_CYC system cycles (from full) have passed since pstate became 11. Until then pstate stays 11.
- R8: ready is 1 exactly when pstate is 00, and is 0 during power-down and power-up.
- R9: At each chip-select falling edge, data_valid becomes 1 if pstate is 00 and 0 otherwise. It holds that value until the next frame starts, so a dummy wake frame reads 0 and the next frame reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select from the host, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| pstate | output | 2 | Power state: 00 normal, 01 partial, 10 full, 11 powering up |
| ready | output | 1 | Device fully powered up |
| data_valid | output | 1 | Data of the current or last frame is valid |

## Verification
The bench builds the block with PU_PART_CYC of 8 and PU_FULL_CYC of 400 system cycles, and each serial-clock half period lasts four system cycles. With these values a partial wake finishes inside its own dummy frame. A full wake is still in progress well after the frame ends, so the bench can observe pstate 11 for a long stretch and then the change to 00. The same values keep the deep-sleep path, the glitch path and every window boundary (1, 2, 9, 10 edges) within a run of a few thousand cycles.

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl #(
  parameter int PU_PART_CYC = 100,
  parameter int PU_FULL_CYC = 2000,
  parameter int ECNT_W      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  output logic [1:0] pstate,
  output logic       ready,
  output logic       data_valid
);

  localparam int PU_MAX = (PU_FULL_CYC > PU_PART_CYC) ? PU_FULL_CYC : PU_PART_CYC;
  localparam int TW = $clog2(PU_MAX + 1);
  localparam logic [TW-1:0] LIM_P = TW'(PU_PART_CYC);
  localparam logic [TW-1:0] LIM_F = TW'(PU_FULL_CYC);
  localparam logic [ECNT_W-1:0] EMAX = '1;
  localparam logic [ECNT_W-1:0] E2 = ECNT_W'(2);
  localparam logic [ECNT_W-1:0] E10 = ECNT_W'(10);

  localparam logic [1:0] ST_NORM = 2'b00;
  localparam logic [1:0] ST_PART = 2'b01;
  localparam logic [1:0] ST_FULL = 2'b10;
  localparam logic [1:0] ST_WAKE = 2'b11;

  logic [1:0] cs_s, sc_s;
  logic       cs_d, sc_d;
  logic [ECNT_W-1:0] ecnt;
  logic [TW-1:0] timer;
  logic [1:0] st;
  logic from_full, armed, dv;

  wire cs_q    = cs_s[1];
  wire cs_fall = cs_d & ~cs_q;
  wire cs_rise = ~cs_d & cs_q;
  wire sc_fall = sc_d & ~sc_s[1] & ~cs_q;
  wire in_win  = (ecnt >= E2) && (ecnt < E10);
  wire past10  = (ecnt >= E10);
  wire [TW-1:0] limit = from_full ? LIM_F : LIM_P;
  wire tdone   = (timer >= limit);

  assign pstate     = st;
  assign ready      = (st == ST_NORM);
  assign data_valid = dv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= 2'b11;
      sc_s <= 2'b11;
      cs_d <= 1'b1;
      sc_d <= 1'b1;
    end else begin
      cs_s <= {cs_s[0], cs_n};
      sc_s <= {sc_s[0], sclk};
      cs_d <= cs_s[1];
      sc_d <= sc_s[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ecnt <= '0;
    else if (cs_fall)
      ecnt <= '0;
    else if (sc_fall && ecnt != EMAX)
      ecnt <= ecnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_NORM;
      from_full <= 1'b0;
      armed     <= 1'b0;
      timer     <= '0;
      dv        <= 1'b0;
    end else begin
      case (st)
        ST_NORM: begin
          if (cs_fall) dv <= 1'b1;
          if (cs_rise && in_win) st <= ST_PART;
        end
        ST_PART, ST_FULL: begin
          if (cs_fall) begin
            st        <= ST_WAKE;
            from_full <= (st == ST_FULL);
            armed     <= 1'b0;
            timer     <= '0;
            dv        <= 1'b0;
          end
        end
        default: begin
          if (!tdone) timer <= timer + 1'b1;
          if (cs_fall) dv <= 1'b0;
          if (past10) armed <= 1'b1;
          if ((armed || past10) && tdone)
            st <= ST_NORM;
          else if (cs_rise && !armed && !past10)
            st <= (from_full || in_win) ? ST_FULL : ST_PART;
        end
      endcase
    end
  end

  p_norm_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NORM) |=> (st == ST_NORM || st == ST_PART));

  p_part_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PART) |=> (st != ST_NORM));

  p_full_stay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FULL) |=> (st == ST_FULL || st == ST_WAKE));

  p_wake_timer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAKE && !tdone) |=> (st != ST_NORM));

  p_ready_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(st) == ST_WAKE));

  p_dv_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> ($past(st) == ST_NORM && $past(cs_fall)));

endmodule

// File: tb/sim_adc_pwr_ctrl.sv
module sim_adc_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PU_P = 8;
  localparam int PU_F = 400;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic [1:0] pstate;
  logic ready, data_valid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pwr_ctrl #(.PU_PART_CYC(PU_P), .PU_FULL_CYC(PU_F)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .pstate(pstate), .ready(ready), .data_valid(data_valid));

  // {edges[3:0], expected pstate[1:0], expected data_valid}
  localparam int NV = 7;
  localparam logic [6:0] VEC [NV] = '{
    {4'd14, 2'b00, 1'b1},  // R3 complete frame
    {4'd1,  2'b00, 1'b1},  // R3 glitch in normal
    {4'd5,  2'b01, 1'b1},  // R2 abort to partial
    {4'd1,  2'b01, 1'b0},  // R4 glitch in partial
    {4'd3,  2'b10, 1'b0},  // R5 partial to full
    {4'd9,  2'b10, 1'b0},  // R6 abort from full at 9
    {4'd2,  2'b10, 1'b0}   // R6 abort from full at 2
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; wait_clk(HALF);
      sclk = 1'b1; wait_clk(HALF);
    end
  endtask

  task automatic frame(int n);
    @(negedge clk) cs_n = 1'b0;
    wait_clk(HALF);
    edges(n);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    wait_clk(3);
    check("R1 pstate", 32'(pstate), 32'd0);
    check("R1 ready", 32'(ready), 32'd1);
    check("R1 data_valid", 32'(data_valid), 32'd0);
    rst_n = 1'b1;
    wait_clk(3);

    for (int v = 0; v < NV; v++) begin
      frame(int'(VEC[v][6:3]));
      check($sformatf("R2/R3/R4/R5/R6 vec%0d pstate", v), 32'(pstate), 32'(VEC[v][2:1]));
      check($sformatf("R9 vec%0d data_valid", v), 32'(data_valid), 32'(VEC[v][0]));
    end

    // R7 wake from full: timer counted from pstate becoming 11
    @(negedge clk) cs_n = 1'b0;
    wait_clk(HALF);
    check("R7 powering up from full", 32'(pstate), 32'd3);
    check("R8 ready low while powering up", 32'(ready), 32'd0);
    edges(12);
    cs_n = 1'b1;
    wait_clk(380 - HALF - 12*2*HALF);
    check("R7 full wake still pending", 32'(pstate), 32'd3);
    check("R8 ready low before full power-up", 32'(ready), 32'd0);
    wait_clk(50);
    check("R7 full wake done", 32'(pstate), 32'd0);
    check("R8 ready after full wake", 32'(ready), 32'd1);
    check("R9 dummy frame invalid", 32'(data_valid), 32'd0);

    frame(14);
    check("R9 first frame after wake valid", 32'(data_valid), 32'd1);
    check("R3 frame of 14 stays normal", 32'(pstate), 32'd0);

    frame(9);
    check("R2 abort at 9 edges", 32'(pstate), 32'd1);
    check("R8 ready low in partial", 32'(ready), 32'd0);

    frame(10);
    check("R7 partial wake done", 32'(pstate), 32'd0);
    check("R9 partial dummy invalid", 32'(data_valid), 32'd0);

    frame(2);
    check("R2 abort at 2 edges", 32'(pstate), 32'd1);
    frame(10);
    frame(10);
    check("R3 frame of 10 stays normal", 32'(pstate), 32'd0);
    check("R9 valid after partial wake", 32'(data_valid), 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule